// File: doc/BRIEF.md
# Host Transfer List Scheduler

This block decides which endpoint the host controller should service next within a USB frame. When a frame begins, it looks up a periodic list head from a 32-entry table, using the frame number to pick the entry. It then walks that list and offers each periodic endpoint once. When the periodic list ends, the rest of the frame is shared between the control list and the bulk list. The share is n control services to 1 bulk service, and n is set through a small ratio input.

The block keeps its own place in the control list and in the bulk list. Each list picks up at the endpoint where it last stopped, and this holds even across frame boundaries. When a list reaches a null link, it starts again from that list's head pointer. A head pointer of zero marks the list as empty.

The block presents an endpoint address together with a kind code. The servicing logic replies with a done pulse and the endpoint's next link. Fetching descriptors, running the transfers and accessing memory are all handled elsewhere.

Top module: `list_sched`

## Requirements
- R1: After reset, `svc_valid` stays low until the first `frame_start` pulse, whatever the head pointer inputs are.
- R2: A `frame_start` pulse loads the periodic pointer from the table entry selected by the low 5 bits of `frame_num`. Table entries are written through `tbl_wr_en`/`tbl_wr_idx`/`tbl_wr_ptr`, and all entries reset to zero.
- R3: In the periodic phase, the scheduler offers each address in turn. It follows the `svc_next` link returned with each `svc_done`. When the pointer becomes zero, it moves to the shared control/bulk phase.
- R4: When both lists are non-empty, the scheduler offers exactly n control endpoints and then one bulk endpoint, repeating. Here n = `ratio` + 1.
- R5: The control and bulk positions are each kept between passes and between frames. A list resumes at the endpoint after the last one serviced.
- R6: A zero `svc_next` returned for a control or bulk endpoint makes that list restart at its head pointer the next time it is chosen.
- R7: A list whose head input is zero is treated as empty and is skipped, so the other list receives every slot regardless of the ratio.
- R8: If both heads are zero during the shared phase, `svc_valid` stays low until the next `frame_start`, even if a head becomes non-zero meanwhile.
- R9: A `frame_start` pulse always returns the scheduler to the periodic phase, including in the middle of a periodic walk, and leaves the control and bulk positions unchanged.
- R10: `svc_kind` is 1 for periodic, 2 for control and 3 for bulk whenever `svc_valid` is high, and `svc_addr` is then non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| frame_num | input | 11 | Current frame number; the low 5 bits pick the periodic head |
| tbl_wr_en | input | 1 | Write strobe for the periodic head table |
| tbl_wr_idx | input | 5 | Table entry to write |
| tbl_wr_ptr | input | 32 | Head pointer value to write |
| ctrl_head | input | 32 | Control list head pointer (zero means empty) |
| bulk_head | input | 32 | Bulk list head pointer (zero means empty) |
| ratio | input | 2 | Control-to-bulk ratio code, n = ratio + 1 |
| svc_valid | output | 1 | An endpoint is offered for service |
| svc_kind | output | 2 | 1 periodic, 2 control, 3 bulk |
| svc_addr | output | 32 | Address of the endpoint to service |
| svc_done | input | 1 | Offered endpoint has been serviced |
| svc_next | input | 32 | Next-endpoint link of the serviced endpoint |

## Verification
The assertions check the following on every cycle. An offered address is never zero, and the kind code is always legal. The cycle after a frame start never offers a non-periodic endpoint. No periodic endpoint appears after shared service has begun within a frame. A list with a zero head is never offered. A run of control services never exceeds n while bulk work exists.

Some behaviours need a remembered sequence, and only the bench scenarios can show them. These are the exact order of the ratio interleave, resumption at the stored position across frames, reloading after a null link, and staying idle until the next frame once both lists are empty.

// File: rtl/ls_pkg.sv
// Shared encodings for the host transfer list scheduler.
// Assumes: a two-bit kind code is enough to tag every offered endpoint.
package ls_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_PER  = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_BULK = 2'd3
    } svc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PER   = 2'd1,
        ST_SHARE = 2'd2,
        ST_WAIT  = 2'd3
    } sched_st_e;
endpackage

// File: rtl/ls_period_table.sv
// Table of periodic list heads, one for each frame slot.
// Assumes: a single write port and a combinational read, with entries cleared by reset.
module ls_period_table #(
    parameter int AW    = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [AW-1:0]    wr_ptr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_ptr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [AW-1:0] slots [DEPTH];

    // Clear or write table entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_idx] <= wr_ptr;
        end
    end

    // Read the head for the current frame slot.
    always_comb rd_ptr = slots[rd_idx];
endmodule

// File: rtl/ls_resume_ptr.sv
// Resume pointer for one asynchronous list (control or bulk).
// A stored value of zero means "start at the head"; otherwise the list resumes there.
// Assumes: adv pulses only when this list's endpoint has been serviced.
module ls_resume_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] head,
    input  logic          adv,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] cur_addr,
    output logic          nonempty
);
    logic [AW-1:0] pos;

    // Remember the link of the last serviced endpoint.
    always_ff @(posedge clk) begin
        if (!rst_n)   pos <= '0;
        else if (adv) pos <= link;
    end

    // Pick the resume point, or reload from the head after a null link.
    always_comb begin
        nonempty = (head != '0);
        cur_addr = (pos != '0) ? pos : head;
    end
endmodule

// File: rtl/ls_ratio_arb.sv
// Chooses between control and bulk at an n:1 ratio, where n = ratio + 1.
// An empty list gives its slots to the other list.
// Assumes: ctrl_adv and bulk_adv never pulse together.
module ls_ratio_arb #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               ctrl_ne,
    input  logic               bulk_ne,
    input  logic               ctrl_adv,
    input  logic               bulk_adv,
    output logic               pick_bulk,
    output logic               any_ne
);
    localparam int CW = RATIO_W + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] run;
    logic [CW-1:0] n_val;

    // Count the control services since the last bulk service, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                         run <= '0;
        else if (bulk_adv)                  run <= '0;
        else if (ctrl_adv && run != CMAX)   run <= run + 1'b1;
    end

    // Send bulk once n control services have happened, or when control is empty.
    always_comb begin
        n_val     = {1'b0, ratio} + 1'b1;
        any_ne    = ctrl_ne | bulk_ne;
        pick_bulk = bulk_ne && (!ctrl_ne || run >= n_val);
    end
endmodule

// File: rtl/list_sched.sv
// Host transfer list scheduler: walks the periodic list for the frame, then
// shares the rest of the frame between control and bulk at an n:1 ratio.
// Assumes: svc_done is only raised while svc_valid is high; frame_start is a single-cycle pulse.
module list_sched #(
    parameter int AW      = 32,
    parameter int FN_W    = 11,
    parameter int IDX_W   = 5,
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [FN_W-1:0]    frame_num,
    input  logic               tbl_wr_en,
    input  logic [IDX_W-1:0]   tbl_wr_idx,
    input  logic [AW-1:0]      tbl_wr_ptr,
    input  logic [AW-1:0]      ctrl_head,
    input  logic [AW-1:0]      bulk_head,
    input  logic [RATIO_W-1:0] ratio,
    output logic               svc_valid,
    output logic [1:0]         svc_kind,
    output logic [AW-1:0]      svc_addr,
    input  logic               svc_done,
    input  logic [AW-1:0]      svc_next
);
    import ls_pkg::*;

    localparam int NLIST = 2;

    sched_st_e     st;
    logic [AW-1:0] per_ptr;
    logic [AW-1:0] tbl_head;
    logic          pick_bulk;
    logic          any_ne;
    logic          done_ok;
    logic [AW-1:0] heads    [NLIST];
    logic [AW-1:0] cur_addr [NLIST];
    logic          list_ne  [NLIST];
    logic          list_adv [NLIST];

    ls_period_table #(.AW(AW), .IDX_W(IDX_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_ptr (tbl_wr_ptr),
        .rd_idx (frame_num[IDX_W-1:0]),
        .rd_ptr (tbl_head)
    );

    // Collect the list heads and the advance strobes (index 0 control, 1 bulk).
    always_comb begin
        heads[0]    = ctrl_head;
        heads[1]    = bulk_head;
        done_ok     = svc_done && svc_valid && (st == ST_SHARE);
        list_adv[0] = done_ok && !pick_bulk;
        list_adv[1] = done_ok &&  pick_bulk;
    end

    for (genvar g = 0; g < NLIST; g++) begin : g_list
        ls_resume_ptr #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .head     (heads[g]),
            .adv      (list_adv[g]),
            .link     (svc_next),
            .cur_addr (cur_addr[g]),
            .nonempty (list_ne[g])
        );
    end

    ls_ratio_arb #(.RATIO_W(RATIO_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio     (ratio),
        .ctrl_ne   (list_ne[0]),
        .bulk_ne   (list_ne[1]),
        .ctrl_adv  (list_adv[0]),
        .bulk_adv  (list_adv[1]),
        .pick_bulk (pick_bulk),
        .any_ne    (any_ne)
    );

    // Phase sequencing: a frame start always wins and reloads the periodic walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            per_ptr <= '0;
        end else if (frame_start) begin
            st      <= ST_PER;
            per_ptr <= tbl_head;
        end else begin
            case (st)
                ST_PER: begin
                    if (per_ptr == '0)  st      <= ST_SHARE;
                    else if (svc_done)  per_ptr <= svc_next;
                end
                ST_SHARE: if (!any_ne) st <= ST_WAIT;
                default: ;
            endcase
        end
    end

    // Present the endpoint selected in the current phase.
    always_comb begin
        svc_valid = 1'b0;
        svc_kind  = KIND_NONE;
        svc_addr  = '0;
        if (st == ST_PER && per_ptr != '0) begin
            svc_valid = 1'b1;
            svc_kind  = KIND_PER;
            svc_addr  = per_ptr;
        end else if (st == ST_SHARE && any_ne) begin
            svc_valid = 1'b1;
            svc_kind  = pick_bulk ? KIND_BULK : KIND_CTRL;
            svc_addr  = pick_bulk ? cur_addr[1] : cur_addr[0];
        end
    end
endmodule

// File: rtl/ls_sched_chk.sv
// Checker for list_sched, attached to the top module with bind.
// Assumes: the port names match the top module; it watches ports only.
module ls_sched_chk #(
    parameter int AW      = 32,
    parameter int RATIO_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic [AW-1:0]      ctrl_head,
    input logic [AW-1:0]      bulk_head,
    input logic [RATIO_W-1:0] ratio,
    input logic               svc_valid,
    input logic [1:0]         svc_kind,
    input logic [AW-1:0]      svc_addr,
    input logic               svc_done
);
    localparam int RW = RATIO_W + 2;
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    logic          shared_seen;
    logic [RW-1:0] ctrl_run;

    // Track whether shared service has started in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)                  shared_seen <= 1'b0;
        else if (svc_valid && svc_kind != 2'd1)     shared_seen <= 1'b1;
    end

    // Count the control services completed since the last bulk service.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_run <= '0;
        else if (svc_done && svc_valid && svc_kind == 2'd3) ctrl_run <= '0;
        else if (svc_done && svc_valid && svc_kind == 2'd2 && ctrl_run != RMAX)
            ctrl_run <= ctrl_run + 1'b1;
    end

    assert_addr_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (svc_addr != '0 && svc_kind != 2'd0));

    assert_frame_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!svc_valid || svc_kind == 2'd1));

    assert_periodic_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && shared_seen) |-> svc_kind != 2'd1);

    assert_skip_empty_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_kind == 2'd2) |-> ctrl_head != '0);

    assert_skip_empty_bulk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_kind == 2'd3) |-> bulk_head != '0);

    assert_ratio_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_kind == 2'd2 && bulk_head != '0)
            |-> ctrl_run < ({2'b00, ratio} + 1'b1));
endmodule

bind list_sched ls_sched_chk #(.AW(AW), .RATIO_W(RATIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .ctrl_head   (ctrl_head),
    .bulk_head   (bulk_head),
    .ratio       (ratio),
    .svc_valid   (svc_valid),
    .svc_kind    (svc_kind),
    .svc_addr    (svc_addr),
    .svc_done    (svc_done)
);

// File: tb/sim_list_sched.sv
// Directed bench for list_sched: one task per scenario, each checking its own results.
module sim_list_sched;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_PER = 2'd1, K_CTRL = 2'd2, K_BULK = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [10:0] frame_num = '0;
    logic        tbl_wr_en = 1'b0;
    logic [4:0]  tbl_wr_idx = '0;
    logic [31:0] tbl_wr_ptr = '0;
    logic [31:0] ctrl_head = '0;
    logic [31:0] bulk_head = '0;
    logic [1:0]  ratio = '0;
    logic        svc_valid;
    logic [1:0]  svc_kind;
    logic [31:0] svc_addr;
    logic        svc_done = 1'b0;
    logic [31:0] svc_next = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    list_sched u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_num(frame_num),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_ptr(tbl_wr_ptr),
        .ctrl_head(ctrl_head), .bulk_head(bulk_head), .ratio(ratio),
        .svc_valid(svc_valid), .svc_kind(svc_kind), .svc_addr(svc_addr),
        .svc_done(svc_done), .svc_next(svc_next)
    );

    // Memory model of the endpoint links.
    function automatic logic [31:0] link_of(input logic [31:0] a);
        case (a)
            32'h100: return 32'h140;
            32'h010: return 32'h014;
            32'h014: return 32'h018;
            32'h080: return 32'h084;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual valid/kind/addr=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_frame(input logic [10:0] fn);
        frame_num = fn; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic tbl_write(input logic [4:0] idx, input logic [31:0] p);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_ptr = p;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Wait briefly for an offer, check it, then complete it with its link.
    task automatic serve(input logic [1:0] k, input logic [31:0] a, input string req);
        for (int w = 0; w < 4 && !svc_valid; w++) @(negedge clk);
        check(req, {svc_valid, svc_kind, svc_addr}, {1'b1, k, a});
        svc_done = 1'b1; svc_next = link_of(svc_addr);
        @(negedge clk);
        svc_done = 1'b0; svc_next = '0;
    endtask

    task automatic expect_idle(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            check(req, {svc_valid, 34'h0}, 35'h0);
            @(negedge clk);
        end
    endtask

    // R1: no offer after reset until a frame starts.
    task automatic t_reset;
        ctrl_head = 32'h10; bulk_head = 32'h80; ratio = 2'd1;
        expect_idle(4, "R1");
    endtask

    // R2, R3, R4, R6: periodic walk of frame 35 (slot 3), then 2:1 interleave with reload.
    task automatic t_periodic_ratio;
        tbl_write(5'd3, 32'h100);
        tbl_write(5'd5, 32'h200);
        pulse_frame(11'd35);
        serve(K_PER, 32'h100, "R2");
        serve(K_PER, 32'h140, "R3");
        serve(K_CTRL, 32'h10, "R3");
        serve(K_CTRL, 32'h14, "R4");
        serve(K_BULK, 32'h80, "R4");
        serve(K_CTRL, 32'h18, "R4");
        serve(K_CTRL, 32'h10, "R6");
        serve(K_BULK, 32'h84, "R4");
    endtask

    // R5, R9: resume across frames, and a frame start that interrupts a periodic walk.
    task automatic t_resume_override;
        pulse_frame(11'd7);
        serve(K_CTRL, 32'h14, "R5");
        serve(K_CTRL, 32'h18, "R5");
        serve(K_BULK, 32'h80, "R5");
        pulse_frame(11'd3);
        serve(K_PER, 32'h100, "R9");
        check("R9", {svc_valid, svc_kind, svc_addr}, {1'b1, K_PER, 32'h140});
        pulse_frame(11'd5);
        serve(K_PER, 32'h200, "R9");
        serve(K_CTRL, 32'h10, "R9");
        serve(K_CTRL, 32'h14, "R9");
        serve(K_BULK, 32'h84, "R9");
    endtask

    // R4: ratio code 3 gives four control services per bulk service.
    task automatic t_ratio4;
        ratio = 2'd3;
        pulse_frame(11'd7);
        serve(K_CTRL, 32'h18, "R4");
        serve(K_CTRL, 32'h10, "R4");
        serve(K_CTRL, 32'h14, "R4");
        serve(K_CTRL, 32'h18, "R4");
        serve(K_BULK, 32'h80, "R4");
        serve(K_CTRL, 32'h10, "R4");
    endtask

    // R7: an empty list is skipped and the other list takes every slot.
    task automatic t_empty_skip;
        ratio = 2'd0; bulk_head = 32'h0;
        @(negedge clk);
        serve(K_CTRL, 32'h14, "R7");
        serve(K_CTRL, 32'h18, "R7");
        serve(K_CTRL, 32'h10, "R7");
        serve(K_CTRL, 32'h14, "R7");
        ctrl_head = 32'h0; bulk_head = 32'h80;
        @(negedge clk);
        serve(K_BULK, 32'h84, "R7");
        serve(K_BULK, 32'h80, "R7");
        serve(K_BULK, 32'h84, "R7");
    endtask

    // R8: both lists empty means idle until the next frame.
    task automatic t_both_empty;
        bulk_head = 32'h0;
        @(negedge clk);
        expect_idle(6, "R8");
        ctrl_head = 32'h10;
        expect_idle(6, "R8");
        pulse_frame(11'd7);
        serve(K_CTRL, 32'h18, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic_ratio();
        t_resume_override();
        t_ratio4();
        t_empty_skip();
        t_both_empty();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule